// File: doc/BRIEF.md
# Ring Buffer Write Pointer

This block tracks where the next received word lands in a circular buffer placed anywhere in a 32-bit byte address space. Software programs a base address, a buffer length in bytes and a fill-level threshold. Each time the data path accepts a word it pulses a strobe. The block advances an internal byte offset by the word size and presents the absolute write address for the word now on offer.

When a word fills the last slot, the offset folds back to zero and a sticky end-of-buffer flag is raised. A second sticky flag marks the point in each pass where the bytes written reach the programmed threshold. Each flag has an enable that gates it onto an interrupt line. Software clears a flag by pulsing its clear input. If the base or length is changed, the pointer restarts at the new base.

Top module: `ring_wr_ptr`

## Requirements
- R1: After reset the offset is zero, so `wr_addr` equals `buf_base`, and both flags and both interrupt outputs are low.
- R2: `wr_addr` is `buf_base` plus the current offset and is the address of the word offered in this cycle. A word accepted with `word_vld` high adds `WORD_BYTES` (default 4) to the offset, and the new address is visible after the next rising clock edge.
- R3: If the offset plus `WORD_BYTES` is greater than or equal to `buf_len` when a word is accepted, the offset returns to zero and `eob_flag` is set. This end is exclusive. A length below `WORD_BYTES` makes every accepted word wrap.
- R4: `lvl_flag` is set when an accepted word makes the offset plus `WORD_BYTES` exactly equal to `lvl_thresh`. A threshold equal to `buf_len` fires together with the wrap.
- R5: A cycle in which `buf_base` or `buf_len` differs from the value seen in the previous cycle resets the offset to zero. A word strobed in that cycle is discarded and sets no flag. The first cycle after reset only captures the configuration.
- R6: Both flags stay set until cleared. A high `eob_clr` or `lvl_clr` clears the matching flag at the next edge. A set event in the same cycle wins over the clear.
- R7: `eob_irq` is `eob_flag` gated by `eob_ien`, and `lvl_irq` is `lvl_flag` gated by `lvl_ien`, with no register in between. The enables do not change the flags.
- R8: The address sum is taken modulo 2^32, so a buffer may cross the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_vld | input | 1 | One word accepted this cycle |
| buf_base | input | ADDR_W | Buffer start byte address |
| buf_len | input | ADDR_W | Buffer length in bytes |
| lvl_thresh | input | ADDR_W | Fill-level threshold in bytes |
| eob_ien | input | 1 | End-of-buffer interrupt enable |
| lvl_ien | input | 1 | Fill-level interrupt enable |
| eob_clr | input | 1 | Write-one-to-clear for the end-of-buffer flag |
| lvl_clr | input | 1 | Write-one-to-clear for the fill-level flag |
| wr_addr | output | ADDR_W | Address for the word offered now |
| eob_flag | output | 1 | Sticky end-of-buffer status |
| lvl_flag | output | 1 | Sticky fill-level status |
| eob_irq | output | 1 | Masked end-of-buffer interrupt |
| lvl_irq | output | 1 | Masked fill-level interrupt |

## Verification
Two pairs of events can land in the same cycle. A software clear can meet a wrap or threshold hit. A change of base or length can meet an accepted word. The bench provokes the first pair by raising `eob_clr` and `lvl_clr` on the exact word that wraps with the threshold equal to the length, and expects both flags to stay set. It provokes the second by moving the base while strobing a word, and expects the offset to restart at zero with no flag raised. A behavioural model also compares every output on every cycle during a pseudo-random stretch in which these collisions recur.

// File: rtl/rwp_pkg.sv
package rwp_pkg;

    // One-cycle event pulses produced by the offset tracker
    typedef struct packed {
        logic wrap;
        logic lvl;
    } rwp_evt_t;

    localparam int unsigned NUM_FLAGS = 2;
    localparam int unsigned FLAG_EOB  = 0;
    localparam int unsigned FLAG_LVL  = 1;

endpackage

// File: rtl/rwp_cfg_watch.sv
module rwp_cfg_watch #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] len_i,
    output logic              chg_o
);

    typedef struct packed {
        logic              primed;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] len;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.primed = 1'b1;
        st_d.base   = base_i;
        st_d.len    = len_i;
        chg_o       = st_q.primed && ((base_i != st_q.base) || (len_i != st_q.len));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rwp_offset.sv
module rwp_offset
    import rwp_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              chg_i,
    input  logic [ADDR_W-1:0] len_i,
    input  logic [ADDR_W-1:0] thresh_i,
    output logic [ADDR_W-1:0] off_o,
    output rwp_evt_t          evt_o
);

    localparam logic [ADDR_W:0] STEP = (ADDR_W+1)'(WORD_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] off;
    } st_t;

    st_t             st_d, st_q;
    logic [ADDR_W:0] nxt;
    logic            take;

    always_comb begin
        st_d       = st_q;
        take       = adv_i && !chg_i;
        nxt        = {1'b0, st_q.off} + STEP;
        evt_o.wrap = take && (nxt >= {1'b0, len_i});
        evt_o.lvl  = take && (nxt == {1'b0, thresh_i});
        if (chg_i) begin
            st_d.off = '0;
        end else if (take) begin
            st_d.off = evt_o.wrap ? '0 : nxt[ADDR_W-1:0];
        end
        off_o = st_q.off;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rwp_sticky.sv
module rwp_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic ien_i,
    output logic flag_o,
    output logic irq_o
);

    typedef struct packed {
        logic flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
        flag_o = st_q.flag;
        irq_o  = st_q.flag && ien_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ring_wr_ptr.sv
module ring_wr_ptr
    import rwp_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [ADDR_W-1:0] buf_base,
    input  logic [ADDR_W-1:0] buf_len,
    input  logic [ADDR_W-1:0] lvl_thresh,
    input  logic              eob_ien,
    input  logic              lvl_ien,
    input  logic              eob_clr,
    input  logic              lvl_clr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              eob_flag,
    output logic              lvl_flag,
    output logic              eob_irq,
    output logic              lvl_irq
);

    logic                 cfg_chg;
    logic [ADDR_W-1:0]    off;
    rwp_evt_t             evt;
    logic                 wrap_pls;
    logic                 lvl_pls;
    logic [NUM_FLAGS-1:0] f_set, f_clr, f_ien, f_flag, f_irq;

    rwp_cfg_watch #(.ADDR_W(ADDR_W)) u_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .base_i (buf_base),
        .len_i  (buf_len),
        .chg_o  (cfg_chg)
    );

    rwp_offset #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_off (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (word_vld),
        .chg_i    (cfg_chg),
        .len_i    (buf_len),
        .thresh_i (lvl_thresh),
        .off_o    (off),
        .evt_o    (evt)
    );

    always_comb begin
        wrap_pls        = evt.wrap;
        lvl_pls         = evt.lvl;
        f_set[FLAG_EOB] = wrap_pls;
        f_set[FLAG_LVL] = lvl_pls;
        f_clr[FLAG_EOB] = eob_clr;
        f_clr[FLAG_LVL] = lvl_clr;
        f_ien[FLAG_EOB] = eob_ien;
        f_ien[FLAG_LVL] = lvl_ien;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        rwp_sticky u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (f_set[g]),
            .clr_i  (f_clr[g]),
            .ien_i  (f_ien[g]),
            .flag_o (f_flag[g]),
            .irq_o  (f_irq[g])
        );
    end

    assign wr_addr  = buf_base + off;
    assign eob_flag = f_flag[FLAG_EOB];
    assign lvl_flag = f_flag[FLAG_LVL];
    assign eob_irq  = f_irq[FLAG_EOB];
    assign lvl_irq  = f_irq[FLAG_LVL];

endmodule

// File: rtl/ring_wr_ptr_chk.sv
module ring_wr_ptr_chk #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_vld,
    input logic [ADDR_W-1:0] buf_base,
    input logic [ADDR_W-1:0] buf_len,
    input logic [ADDR_W-1:0] lvl_thresh,
    input logic              eob_ien,
    input logic              lvl_ien,
    input logic              eob_clr,
    input logic              lvl_clr,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              eob_flag,
    input logic              lvl_flag,
    input logic              eob_irq,
    input logic              lvl_irq,
    input logic              cfg_chg,
    input logic [ADDR_W-1:0] off,
    input logic              wrap_pls,
    input logic              lvl_pls
);

    localparam logic [ADDR_W:0] STEP = (ADDR_W+1)'(WORD_BYTES);

    logic [ADDR_W:0] nxt;
    assign nxt = {1'b0, off} + STEP;

    // R2: plain advance moves the address by one word
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && !cfg_chg && (nxt < {1'b0, buf_len}))
        |=> (!$stable(buf_base) || (wr_addr == $past(wr_addr) + ADDR_W'(WORD_BYTES))));

    // R3: wrap returns to the base and raises end-of-buffer
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && !cfg_chg && (nxt >= {1'b0, buf_len}))
        |=> (eob_flag && (wr_addr == buf_base)));

    // R4: threshold hit raises the level flag
    p_lvl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && !cfg_chg && (nxt == {1'b0, lvl_thresh})) |=> lvl_flag);

    // R5: configuration change restarts at the base, no events
    p_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (wr_addr == buf_base));
    p_cfg_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |-> (!wrap_pls && !lvl_pls));

    // R6: flags hold without a clear, clear takes effect without a set
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eob_flag && !eob_clr) |=> eob_flag);
    p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_clr && !lvl_pls) |=> !lvl_flag);
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eob_clr && wrap_pls) |=> eob_flag);

    // R7: masked interrupts
    p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!eob_ien |-> !eob_irq) and (!lvl_ien |-> !lvl_irq));

    // R1: reset state visible at the ports
    always_comb begin
        if (!rst_n) begin
            a_reset_r1: assert (!eob_flag && !lvl_flag && (wr_addr == buf_base));
        end
    end

endmodule

bind ring_wr_ptr ring_wr_ptr_chk #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_vld   (word_vld),
    .buf_base   (buf_base),
    .buf_len    (buf_len),
    .lvl_thresh (lvl_thresh),
    .eob_ien    (eob_ien),
    .lvl_ien    (lvl_ien),
    .eob_clr    (eob_clr),
    .lvl_clr    (lvl_clr),
    .wr_addr    (wr_addr),
    .eob_flag   (eob_flag),
    .lvl_flag   (lvl_flag),
    .eob_irq    (eob_irq),
    .lvl_irq    (lvl_irq),
    .cfg_chg    (cfg_chg),
    .off        (off),
    .wrap_pls   (wrap_pls),
    .lvl_pls    (lvl_pls)
);

// File: tb/ring_wr_ptr_tb_top.sv
`timescale 1ns/1ps
module ring_wr_ptr_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_vld = 1'b0;
    logic [31:0] buf_base = 32'h0000_1000;
    logic [31:0] buf_len = 32'h20;
    logic [31:0] lvl_thresh = 32'h10;
    logic        eob_ien = 1'b1;
    logic        lvl_ien = 1'b1;
    logic        eob_clr = 1'b0;
    logic        lvl_clr = 1'b0;
    logic [31:0] wr_addr;
    logic        eob_flag, lvl_flag, eob_irq, lvl_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    longint unsigned m_off = 0;
    bit              m_eob = 0, m_lvl = 0, m_primed = 0;
    logic [31:0]     m_base = 0, m_len = 0;

    always #5 clk = ~clk;

    ring_wr_ptr dut_i (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld),
        .buf_base(buf_base), .buf_len(buf_len), .lvl_thresh(lvl_thresh),
        .eob_ien(eob_ien), .lvl_ien(lvl_ien), .eob_clr(eob_clr), .lvl_clr(lvl_clr),
        .wr_addr(wr_addr), .eob_flag(eob_flag), .lvl_flag(lvl_flag),
        .eob_irq(eob_irq), .lvl_irq(lvl_irq)
    );

    task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit chg, wr, lv;
        longint unsigned nxt;
        chg = m_primed && ((buf_base != m_base) || (buf_len != m_len));
        wr = 0; lv = 0;
        if (chg) begin
            m_off = 0;
        end else if (word_vld) begin
            nxt = m_off + 4;
            if (nxt >= buf_len) begin wr = 1; m_off = 0; end
            else m_off = nxt;
            if (nxt == lvl_thresh) lv = 1;
        end
        m_eob = wr ? 1'b1 : (eob_clr ? 1'b0 : m_eob);
        m_lvl = lv ? 1'b1 : (lvl_clr ? 1'b0 : m_lvl);
        m_primed = 1; m_base = buf_base; m_len = buf_len;
    endtask

    task automatic compare_all();
        logic [31:0] ea;
        ea = buf_base + m_off[31:0];
        chk("R2 wr_addr", wr_addr, ea);
        chk("R3 eob_flag", eob_flag, m_eob);
        chk("R4 lvl_flag", lvl_flag, m_lvl);
        chk("R7 eob_irq", eob_irq, m_eob & eob_ien);
        chk("R7 lvl_irq", lvl_irq, m_lvl & lvl_ien);
    endtask

    // one cycle: inputs already set at a falling edge
    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic words(input int n);
        for (int i = 0; i < n; i++) begin
            word_vld = 1; cyc();
        end
        word_vld = 0;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        #22;
        // R1: reset state
        chk("R1 wr_addr", wr_addr, 32'h1000);
        chk("R1 eob_flag", eob_flag, 0);
        chk("R1 lvl_flag", lvl_flag, 0);
        chk("R1 irqs", {eob_irq, lvl_irq}, 0);
        @(negedge clk); rst_n = 1;
        cyc();  // R5: first cycle only captures the configuration
        // R2, R4: eight words in a 0x20 byte buffer, level at 0x10
        words(3);
        chk("R2 after three words", wr_addr, 32'h100C);
        chk("R4 not yet", lvl_flag, 0);
        words(1);
        chk("R4 level reached", lvl_flag, 1);
        words(4);
        chk("R3 wrapped to base", wr_addr, 32'h1000);
        chk("R3 eob set", eob_flag, 1);
        // R6: clears
        eob_clr = 1; lvl_clr = 1; cyc(); eob_clr = 0; lvl_clr = 0;
        chk("R6 eob cleared", eob_flag, 0);
        chk("R6 lvl cleared", lvl_flag, 0);
        // R7: enables do not affect flags
        eob_ien = 0; lvl_ien = 0;
        words(8);
        chk("R7 eob flag with irq masked", eob_flag, 1);
        chk("R7 eob irq masked", eob_irq, 0);
        eob_ien = 1; lvl_ien = 1;
        @(negedge clk);
        chk("R7 eob irq unmasked", eob_irq, 1);
        eob_clr = 1; lvl_clr = 1; cyc(); eob_clr = 0; lvl_clr = 0;
        // R6 and R4: clear meets set on the wrapping word, threshold = length
        lvl_thresh = 32'h20;
        words(7);
        word_vld = 1; eob_clr = 1; lvl_clr = 1; cyc();
        word_vld = 0; eob_clr = 0; lvl_clr = 0;
        chk("R6 set wins over clear eob", eob_flag, 1);
        chk("R4 level at wrap, set wins", lvl_flag, 1);
        eob_clr = 1; lvl_clr = 1; cyc(); eob_clr = 0; lvl_clr = 0;
        // R5: base change while a word is strobed
        words(3);
        buf_base = 32'h0000_2000; word_vld = 1; cyc(); word_vld = 0;
        chk("R5 restart at new base", wr_addr, 32'h2000);
        chk("R5 no flag from dropped word", {eob_flag, lvl_flag}, 0);
        // R3: length below one word wraps on every word
        buf_len = 32'h2; cyc();
        words(1);
        chk("R3 tiny buffer wraps", eob_flag, 1);
        chk("R3 tiny buffer address", wr_addr, 32'h2000);
        eob_clr = 1; cyc(); eob_clr = 0;
        // R8: buffer across the top of the address space
        buf_base = 32'hFFFF_FFF8; buf_len = 32'h10; lvl_thresh = 32'h8; cyc();
        words(3);
        chk("R8 modulo address", wr_addr, 32'h0000_0004);
        // mixed stretch with the reference model every cycle
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            word_vld = lfsr[0] | lfsr[1];
            eob_clr  = (lfsr[5:3] == 3'd0);
            lvl_clr  = (lfsr[8:6] == 3'd0);
            eob_ien  = lfsr[9];
            lvl_ien  = lfsr[10];
            if (lfsr[15:11] == 5'd0) buf_base = buf_base + 32'h100;
            if (lfsr[15:11] == 5'd1) buf_len = {26'd0, lfsr[7:2]};
            lvl_thresh = {27'd0, lfsr[12:11], 3'd0};
            cyc();
        end
        word_vld = 0; eob_clr = 0; lvl_clr = 0;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule